// File: doc/BRIEF.md
# TDM Slot Map Sequencer

This block generates the common timing for four synchronous serial time-division buses and tells each bus, slot by slot, which source drives it and which destinations listen. One clock cycle is one bit. Bits form fixed 8-bit slots. A programmable number of slots, up to 128, forms a frame, and a programmable number of frames, up to 32, forms a superframe. A one-bit sync pulse marks the start of every superframe.

The connection pattern comes from a map memory that holds one entry per bus and slot. Each entry carries a source number, a destination bitmask and a continuation flag. The map has two banks. One bank drives the buses, and the host fills the other bank through a single write port. A swap request makes the edited bank active, but only at the next superframe boundary. The swap is therefore atomic for every bus and every slot. Entries are fetched one slot ahead, so the bus outputs are registered values that stay constant for the whole slot.

A continuation entry joins a slot to the slot before it. Groups of two or four 8-bit slots can then carry one wider word, and they appear as a single connection.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: In the first cycle after reset is released, bit_idx, slot_idx and frame_idx are 0, sf_sync is 1, swap_pending is 0, and every bus_src, bus_dst and bus_cont value is 0. The map contents are kept through reset, and bank 0 is the active bank after reset.
- R2: bit_idx counts 0 to 7, one step per cycle, and slot_start is high exactly when bit_idx is 0. After bit 7, slot_idx steps by one. It returns to 0 after slot index slot_last, which gives slot_last+1 slots per frame (1 to 128).
- R3: frame_idx steps by one each time slot_idx returns to 0. It returns to 0 after frame index frame_last, which gives frame_last+1 frames per superframe (1 to 32).
- R4: sf_sync is high for exactly one cycle per superframe, during bit 0 of slot 0 of frame 0.
- R5: During slot s, and after the first slot that follows reset, bus b shows the active-bank entry for bus b and slot s. A non-continuation entry gives bus_src = entry source, bus_dst = entry mask (bit k set means destination k listens) and bus_cont = 0. These outputs change only in a cycle where slot_start is high.
- R6: Slot s uses the same map entry in every frame of a superframe.
- R7: A write (wr_en with wr_bus, wr_slot, wr_cont, wr_src, wr_dst) goes to the bank that is not in use. It has no effect on any output until a later swap makes that bank active.
- R8: A swap_req accepted while swap_pending is 0 raises swap_pending from the next cycle. If the request is registered before the final slot of a superframe begins, the other bank drives the buses from the first cycle of the next superframe. Otherwise it drives them one superframe later. swap_pending falls in the cycle in which the new bank first drives the buses.
- R9: An entry with the continuation flag set, for a slot s greater than 0, repeats the bus_src and bus_dst of slot s-1 and sets bus_cont to 1. On slot 0 the flag is ignored: the entry's own source and mask are used, and bus_cont is 0.
- R10: Each bus has its own map. A write changes only the bus selected by wr_bus (0 to 3).
- R11: A swap_req that arrives while swap_pending is 1 is ignored, so at most one bank swap happens per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one cycle per bus bit |
| rst | input | 1 | Synchronous active-high reset |
| slot_last | input | 7 | Index of the last slot in a frame |
| frame_last | input | 5 | Index of the last frame in a superframe |
| wr_en | input | 1 | Map write strobe (inactive bank) |
| wr_bus | input | 2 | Bus whose map entry is written |
| wr_slot | input | 7 | Slot whose map entry is written |
| wr_cont | input | 1 | Continuation flag of the written entry |
| wr_src | input | 4 | Source number of the written entry |
| wr_dst | input | 16 | Destination mask of the written entry |
| swap_req | input | 1 | Request to activate the edited bank |
| swap_pending | output | 1 | Swap accepted but not yet in effect |
| sf_sync | output | 1 | Superframe sync, first bit of slot 0 frame 0 |
| slot_start | output | 1 | First bit of a slot |
| bit_idx | output | 3 | Bit position inside the slot |
| slot_idx | output | 7 | Slot position inside the frame |
| frame_idx | output | 5 | Frame position inside the superframe |
| bus_src | output | 4x4 | Source number driving each bus |
| bus_dst | output | 4x16 | Destination enables for each bus |
| bus_cont | output | 4 | Current slot continues the previous slot, per bus |

## Verification
The checks that run on every cycle cover the structure of the timing and the bank switch. They confirm the bit step and the slot wrap, that the frame index holds inside a slot, and that the sync pulse lasts a single cycle. They also confirm that the bus outputs move only at slot starts, that a continued slot repeats its predecessor and never sits on slot 0, and that a request raises the pending flag, which may fall only on the sync cycle. Whether the outputs carry the right entry from the right bank can only be shown by the bench scenarios. These include edits while the buses run, double requests, requests just before and just inside the final slot, the longest frame, the longest superframe and a one-slot frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int NUM_BUS = 4;
    localparam int SRC_W   = 4;
    localparam int DST_W   = 16;
    localparam int BUS_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

    // One map word: continuation flag, source number, destination mask
    typedef struct packed {
        logic             cont;
        logic [SRC_W-1:0] src;
        logic [DST_W-1:0] dst;
    } map_entry_t;

    localparam int ENTRY_W = $bits(map_entry_t);

    // What one bus is doing during the current slot
    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DST_W-1:0] dst;
        logic             cont;
    } bus_drive_t;

    // Turn a fetched map word into the drive of the next slot
    function automatic bus_drive_t next_drive(map_entry_t e, bus_drive_t prev, logic head);
        bus_drive_t r;
        if (e.cont && !head) begin
            r.src  = prev.src;
            r.dst  = prev.dst;
            r.cont = 1'b1;
        end else begin
            r.src  = e.src;
            r.dst  = e.dst;
            r.cont = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/tdm_timebase.sv
module tdm_timebase #(
    parameter int SLOT_BITS  = 8,
    parameter int MAX_SLOTS  = 128,
    parameter int MAX_FRAMES = 32,
    localparam int BIT_W   = (SLOT_BITS  > 1) ? $clog2(SLOT_BITS)  : 1,
    localparam int SLOT_W  = (MAX_SLOTS  > 1) ? $clog2(MAX_SLOTS)  : 1,
    localparam int FRAME_W = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SLOT_W-1:0]  slot_last,
    input  logic [FRAME_W-1:0] frame_last,
    output logic [BIT_W-1:0]   bit_idx,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic [FRAME_W-1:0] frame_idx,
    output logic               slot_begin,
    output logic               slot_end,
    output logic [SLOT_W-1:0]  nxt_slot,
    output logic               nxt_head,
    output logic               nxt_sf_start,
    output logic               sf_sync
);

    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

    logic [BIT_W-1:0]   bit_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [FRAME_W-1:0] frame_q;
    logic               at_last_slot;
    logic               at_last_frame;

    // Comparing with >= lets a shrinking limit recover at the next slot
    assign at_last_slot  = (slot_q  >= slot_last);
    assign at_last_frame = (frame_q >= frame_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q   <= '0;
            slot_q  <= '0;
            frame_q <= '0;
        end else if (bit_q == BIT_LAST) begin
            bit_q <= '0;
            if (at_last_slot) begin
                slot_q  <= '0;
                frame_q <= at_last_frame ? '0 : FRAME_W'(frame_q + 1'b1);
            end else begin
                slot_q <= SLOT_W'(slot_q + 1'b1);
            end
        end else begin
            bit_q <= BIT_W'(bit_q + 1'b1);
        end
    end

    assign bit_idx      = bit_q;
    assign slot_idx     = slot_q;
    assign frame_idx    = frame_q;
    assign slot_begin   = (bit_q == '0);
    assign slot_end     = (bit_q == BIT_LAST);
    assign nxt_slot     = at_last_slot ? '0 : SLOT_W'(slot_q + 1'b1);
    assign nxt_head     = at_last_slot;
    assign nxt_sf_start = at_last_slot && at_last_frame;
    assign sf_sync      = (bit_q == '0) && (slot_q == '0) && (frame_q == '0);

endmodule

// File: rtl/tdm_map_mem.sv
module tdm_map_mem
    import tdm_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    localparam int SLOT_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int ADDR_W = SLOT_W + 1,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [BUS_W-1:0]          wr_bus,
    input  logic                      wr_bank,
    input  logic [SLOT_W-1:0]         wr_slot,
    input  map_entry_t                wr_entry,
    input  logic                      rd_en,
    input  logic                      rd_bank,
    input  logic [SLOT_W-1:0]         rd_slot,
    output map_entry_t [NUM_BUS-1:0]  rd_entry
);

    // One two-bank store per bus; bank number is the top address bit
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        map_entry_t store [DEPTH];
        map_entry_t rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bus == BUS_W'(b))) begin
                store[{wr_bank, wr_slot}] <= wr_entry;
            end
            if (rd_en) begin
                rd_q <= store[{rd_bank, rd_slot}];
            end
        end

        assign rd_entry[b] = rd_q;
    end

endmodule

// File: rtl/tdm_bus_drive.sv
module tdm_bus_drive
    import tdm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic                      head,
    input  map_entry_t [NUM_BUS-1:0]  entry,
    output bus_drive_t [NUM_BUS-1:0]  drive
);

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        bus_drive_t drv_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                drv_q <= '0;
            end else if (load) begin
                drv_q <= next_drive(entry[b], drv_q, head);
            end
        end

        assign drive[b] = drv_q;
    end

endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer
    import tdm_pkg::*;
#(
    parameter int SLOT_BITS  = 8,
    parameter int MAX_SLOTS  = 128,
    parameter int MAX_FRAMES = 32,
    localparam int BIT_W   = (SLOT_BITS  > 1) ? $clog2(SLOT_BITS)  : 1,
    localparam int SLOT_W  = (MAX_SLOTS  > 1) ? $clog2(MAX_SLOTS)  : 1,
    localparam int FRAME_W = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [SLOT_W-1:0]               slot_last,
    input  logic [FRAME_W-1:0]              frame_last,
    input  logic                            wr_en,
    input  logic [BUS_W-1:0]                wr_bus,
    input  logic [SLOT_W-1:0]               wr_slot,
    input  logic                            wr_cont,
    input  logic [SRC_W-1:0]                wr_src,
    input  logic [DST_W-1:0]                wr_dst,
    input  logic                            swap_req,
    output logic                            swap_pending,
    output logic                            sf_sync,
    output logic                            slot_start,
    output logic [BIT_W-1:0]                bit_idx,
    output logic [SLOT_W-1:0]               slot_idx,
    output logic [FRAME_W-1:0]              frame_idx,
    output logic [NUM_BUS-1:0][SRC_W-1:0]   bus_src,
    output logic [NUM_BUS-1:0][DST_W-1:0]   bus_dst,
    output logic [NUM_BUS-1:0]              bus_cont
);

    logic                      slot_begin;
    logic                      slot_end;
    logic [SLOT_W-1:0]         nxt_slot;
    logic                      nxt_head;
    logic                      nxt_sf_start;

    logic                      pend_q;
    logic                      rd_bank_q;
    logic                      act_bank_q;
    logic                      head_q;
    logic                      consume;
    logic                      rd_bank;
    logic                      busy;

    map_entry_t                wr_entry;
    map_entry_t [NUM_BUS-1:0]  fetched;
    bus_drive_t [NUM_BUS-1:0]  drive;

    tdm_timebase #(
        .SLOT_BITS  (SLOT_BITS),
        .MAX_SLOTS  (MAX_SLOTS),
        .MAX_FRAMES (MAX_FRAMES)
    ) u_timebase (
        .clk          (clk),
        .rst          (rst),
        .slot_last    (slot_last),
        .frame_last   (frame_last),
        .bit_idx      (bit_idx),
        .slot_idx     (slot_idx),
        .frame_idx    (frame_idx),
        .slot_begin   (slot_begin),
        .slot_end     (slot_end),
        .nxt_slot     (nxt_slot),
        .nxt_head     (nxt_head),
        .nxt_sf_start (nxt_sf_start),
        .sf_sync      (sf_sync)
    );

    // Bank control: the fetch bank flips on the first bit of the final
    // slot of a superframe, and the drive bank follows at the slot end.
    assign consume = slot_begin && nxt_sf_start && pend_q;
    assign rd_bank = consume ? ~rd_bank_q : rd_bank_q;
    assign busy    = pend_q || (rd_bank_q != act_bank_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            rd_bank_q  <= 1'b0;
            act_bank_q <= 1'b0;
            head_q     <= 1'b0;
        end else begin
            if (consume) begin
                rd_bank_q <= ~rd_bank_q;
            end
            pend_q <= (pend_q && !consume) || (swap_req && !busy);
            if (slot_end) begin
                act_bank_q <= rd_bank_q;
            end
            if (slot_begin) begin
                head_q <= nxt_head;
            end
        end
    end

    assign swap_pending = busy;

    always_comb begin
        wr_entry.cont = wr_cont;
        wr_entry.src  = wr_src;
        wr_entry.dst  = wr_dst;
    end

    tdm_map_mem #(
        .MAX_SLOTS (MAX_SLOTS)
    ) u_map (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_bus   (wr_bus),
        .wr_bank  (~rd_bank_q),
        .wr_slot  (wr_slot),
        .wr_entry (wr_entry),
        .rd_en    (slot_begin),
        .rd_bank  (rd_bank),
        .rd_slot  (nxt_slot),
        .rd_entry (fetched)
    );

    tdm_bus_drive u_drive (
        .clk   (clk),
        .rst   (rst),
        .load  (slot_end),
        .head  (head_q),
        .entry (fetched),
        .drive (drive)
    );

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_out
        assign bus_src[b]  = drive[b].src;
        assign bus_dst[b]  = drive[b].dst;
        assign bus_cont[b] = drive[b].cont;
    end

    assign slot_start = slot_begin;

endmodule

// File: rtl/tdm_slot_sequencer_chk.sv
module tdm_slot_sequencer_chk
    import tdm_pkg::*;
#(
    parameter int SLOT_BITS  = 8,
    parameter int MAX_SLOTS  = 128,
    parameter int MAX_FRAMES = 32,
    localparam int BIT_W   = (SLOT_BITS  > 1) ? $clog2(SLOT_BITS)  : 1,
    localparam int SLOT_W  = (MAX_SLOTS  > 1) ? $clog2(MAX_SLOTS)  : 1,
    localparam int FRAME_W = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1
) (
    input logic                            clk,
    input logic                            rst,
    input logic [SLOT_W-1:0]               slot_last,
    input logic                            swap_req,
    input logic                            swap_pending,
    input logic                            sf_sync,
    input logic                            slot_start,
    input logic [BIT_W-1:0]                bit_idx,
    input logic [SLOT_W-1:0]               slot_idx,
    input logic [FRAME_W-1:0]              frame_idx,
    input logic [NUM_BUS-1:0][SRC_W-1:0]   bus_src,
    input logic [NUM_BUS-1:0][DST_W-1:0]   bus_dst,
    input logic [NUM_BUS-1:0]              bus_cont
);

    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

    // R2
    bit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_idx != BIT_LAST) |=> (bit_idx == BIT_W'($past(bit_idx) + 1'b1)) && $stable(slot_idx));

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ((bit_idx == BIT_LAST) && (slot_idx >= slot_last)) |=> (slot_idx == '0));

    // R3
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_start |-> $stable(frame_idx));

    // R4
    sync_single_chk: assert property (@(posedge clk) disable iff (rst)
        sf_sync |=> !sf_sync);

    // R5
    drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_start |-> ($stable(bus_src) && $stable(bus_dst) && $stable(bus_cont)));

    // R8
    swap_rise_chk: assert property (@(posedge clk) disable iff (rst)
        swap_req |=> swap_pending);

    // R8
    swap_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(swap_pending) |-> sf_sync);

    // R9
    cont_not_head_chk: assert property (@(posedge clk) disable iff (rst)
        (|bus_cont) |-> (slot_idx != '0));

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        // R9
        cont_repeat_chk: assert property (@(posedge clk) disable iff (rst)
            (slot_start && bus_cont[b]) |-> ((bus_src[b] == $past(bus_src[b])) && (bus_dst[b] == $past(bus_dst[b]))));
    end

endmodule

bind tdm_slot_sequencer tdm_slot_sequencer_chk #(
    .SLOT_BITS  (SLOT_BITS),
    .MAX_SLOTS  (MAX_SLOTS),
    .MAX_FRAMES (MAX_FRAMES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .slot_last    (slot_last),
    .swap_req     (swap_req),
    .swap_pending (swap_pending),
    .sf_sync      (sf_sync),
    .slot_start   (slot_start),
    .bit_idx      (bit_idx),
    .slot_idx     (slot_idx),
    .frame_idx    (frame_idx),
    .bus_src      (bus_src),
    .bus_dst      (bus_dst),
    .bus_cont     (bus_cont)
);

// File: tb/tdm_slot_sequencer_tb.sv
module tdm_slot_sequencer_tb;
    import tdm_pkg::*;

    localparam int SLOTS  = 128;
    localparam int FRAMES = 32;

    logic                          clk = 1'b0;
    logic                          rst = 1'b1;
    logic [6:0]                    slot_last = '0;
    logic [4:0]                    frame_last = '0;
    logic                          wr_en = 1'b0;
    logic [1:0]                    wr_bus = '0;
    logic [6:0]                    wr_slot = '0;
    logic                          wr_cont = 1'b0;
    logic [3:0]                    wr_src = '0;
    logic [15:0]                   wr_dst = '0;
    logic                          swap_req = 1'b0;
    logic                          swap_pending;
    logic                          sf_sync;
    logic                          slot_start;
    logic [2:0]                    bit_idx;
    logic [6:0]                    slot_idx;
    logic [4:0]                    frame_idx;
    logic [NUM_BUS-1:0][3:0]       bus_src;
    logic [NUM_BUS-1:0][15:0]      bus_dst;
    logic [NUM_BUS-1:0]            bus_cont;

    always #2 clk = ~clk;

    tdm_slot_sequencer u_dut (
        .clk(clk), .rst(rst), .slot_last(slot_last), .frame_last(frame_last),
        .wr_en(wr_en), .wr_bus(wr_bus), .wr_slot(wr_slot), .wr_cont(wr_cont),
        .wr_src(wr_src), .wr_dst(wr_dst), .swap_req(swap_req),
        .swap_pending(swap_pending), .sf_sync(sf_sync), .slot_start(slot_start),
        .bit_idx(bit_idx), .slot_idx(slot_idx), .frame_idx(frame_idx),
        .bus_src(bus_src), .bus_dst(bus_dst), .bus_cont(bus_cont)
    );

    // Reference model state
    logic [3:0]  m_src  [2][NUM_BUS][SLOTS];
    logic [15:0] m_dstm [2][NUM_BUS][SLOTS];
    logic        m_cf   [2][NUM_BUS][SLOTS];
    bit          known  [2];
    int          m_bit, m_slot, m_frame;
    bit          m_pend, m_armed, m_act;
    logic [3:0]  e_src  [NUM_BUS];
    logic [15:0] e_dst  [NUM_BUS];
    logic        e_cont [NUM_BUS];

    int    checks = 0;
    int    fails  = 0;
    string tag_bus  = "R5";
    string tag_pend = "R8";

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit edit_bank();
        return !(m_act ^ m_armed);
    endfunction

    task automatic model_edge();
        bit busy, consume;
        if (rst) begin
            m_bit = 0; m_slot = 0; m_frame = 0;
            m_pend = 0; m_armed = 0; m_act = 0;
            for (int b = 0; b < NUM_BUS; b++) begin
                e_src[b] = '0; e_dst[b] = '0; e_cont[b] = 1'b0;
            end
            return;
        end
        busy = m_pend || m_armed;
        if (wr_en) begin
            m_src [edit_bank()][wr_bus][wr_slot] = wr_src;
            m_dstm[edit_bank()][wr_bus][wr_slot] = wr_dst;
            m_cf  [edit_bank()][wr_bus][wr_slot] = wr_cont;
        end
        consume = (m_bit == 0) && (m_slot >= slot_last) && (m_frame >= frame_last) && m_pend;
        if (consume) m_armed = 1;
        m_pend = (m_pend && !consume) || (swap_req && !busy);
        if (m_bit == 7) begin
            m_bit = 0;
            if (m_slot >= slot_last) begin
                m_slot = 0;
                m_frame = (m_frame >= frame_last) ? 0 : m_frame + 1;
            end else begin
                m_slot++;
            end
            if (m_slot == 0 && m_frame == 0 && m_armed) begin
                m_act = !m_act;
                m_armed = 0;
            end
            for (int b = 0; b < NUM_BUS; b++) begin
                if (m_cf[m_act][b][m_slot] && m_slot != 0) begin
                    e_cont[b] = 1'b1;
                end else begin
                    e_src[b]  = m_src[m_act][b][m_slot];
                    e_dst[b]  = m_dstm[m_act][b][m_slot];
                    e_cont[b] = 1'b0;
                end
            end
        end else begin
            m_bit++;
        end
    endtask

    task automatic compare();
        string t;
        if (rst) return;
        chk("R2", "bit_idx", 32'(bit_idx), 32'(m_bit));
        chk("R2", "slot_start", 32'(slot_start), 32'(m_bit == 0));
        chk("R2", "slot_idx", 32'(slot_idx), 32'(m_slot));
        chk("R3", "frame_idx", 32'(frame_idx), 32'(m_frame));
        chk("R4", "sf_sync", 32'(sf_sync), 32'(m_bit == 0 && m_slot == 0 && m_frame == 0));
        chk(tag_pend, "swap_pending", 32'(swap_pending), 32'(m_pend || m_armed));
        if (known[m_act]) begin
            for (int b = 0; b < NUM_BUS; b++) begin
                t = e_cont[b] ? "R9" : tag_bus;
                chk(t, $sformatf("bus%0d src", b), 32'(bus_src[b]), 32'(e_src[b]));
                chk(t, $sformatf("bus%0d dst", b), 32'(bus_dst[b]), 32'(e_dst[b]));
                chk(t, $sformatf("bus%0d cont", b), 32'(bus_cont[b]), 32'(e_cont[b]));
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset(int sl, int fl);
        rst = 1'b1; wr_en = 1'b0; swap_req = 1'b0;
        slot_last = 7'(sl); frame_last = 5'(fl);
        run(3);
        rst = 1'b0;
        // R1: first cycle after release
        chk("R1", "bit_idx", 32'(bit_idx), 0);
        chk("R1", "slot_idx", 32'(slot_idx), 0);
        chk("R1", "frame_idx", 32'(frame_idx), 0);
        chk("R1", "sf_sync", 32'(sf_sync), 1);
        chk("R1", "swap_pending", 32'(swap_pending), 0);
        chk("R1", "bus_src", 32'(bus_src), 0);
        chk("R1", "bus_dst", 32'(bus_dst[0] | bus_dst[1] | bus_dst[2] | bus_dst[3]), 0);
        chk("R1", "bus_cont", 32'(bus_cont), 0);
    endtask

    // Fill the whole inactive bank of every bus (R10: per-bus contents differ)
    task automatic fill(bit all_cont);
        bit tgt;
        tgt = edit_bank();
        for (int b = 0; b < NUM_BUS; b++) begin
            for (int s = 0; s < SLOTS; s++) begin
                wr_en   = 1'b1;
                wr_bus  = 2'(b);
                wr_slot = 7'(s);
                wr_src  = 4'($urandom);
                wr_dst  = 16'($urandom);
                wr_cont = all_cont ? 1'b1 : (($urandom % 4) == 0);
                step();
            end
        end
        wr_en = 1'b0;
        known[tgt] = 1'b1;
    endtask

    task automatic swap();
        swap_req = 1'b1;
        step();
        swap_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && (m_pend || m_armed); i++) step();
    endtask

    task automatic align(int bitv, int slotv, int framev);
        for (int i = 0; i < 20000 && !(m_bit == bitv && m_slot == slotv && m_frame == framev); i++)
            step();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e));
        known[0] = 1'b0;
        known[1] = 1'b0;

        // Short frames: 6 slots, 3 frames
        do_reset(5, 2);
        tag_bus = "R5"; tag_pend = "R8";
        fill(1'b0);
        swap();
        run(300);
        tag_bus = "R7";              // edit the idle bank while buses run
        fill(1'b0);
        tag_bus = "R6";
        run(450);
        tag_bus = "R10";
        swap();
        run(300);
        wait_idle();

        // R11: repeated requests while pending
        tag_pend = "R11";
        swap(); run(3); swap(); run(3); swap();
        run(320);
        wait_idle();

        // R8: request in the first bit of the final slot (one superframe late)
        tag_pend = "R8";
        align(0, 5, 2);
        swap();
        run(320);
        wait_idle();
        // R8: request in the last bit before the final slot (taken now)
        align(7, 4, 2);
        swap();
        run(200);
        wait_idle();

        // R3: longest frame
        do_reset(127, 1);
        tag_bus = "R3";
        swap();
        run(3 * 2048 + 20);
        wait_idle();

        // R3: longest superframe with short frames
        do_reset(1, FRAMES - 1);
        swap();
        run(1100);
        wait_idle();

        // R9: single-slot frame, continuation flag on slot 0 is ignored
        do_reset(0, 0);
        tag_bus = "R9";
        fill(1'b1);
        swap();
        run(100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule